// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block is the receive half of a programmable serial port. It watches a serial input line and uses its own oversampling strobe, `rx_tick`, to time that line. The strobe comes from a divider that is separate from the transmit side, so the receive and transmit directions can run at different baud rates. Each bit time is 16 strobes or 64 strobes, selected by `cfg_x64`.

When the line is seen low, the receiver waits half a bit time and samples the line again. If the line is still low, the low is taken as a start bit. The receiver then samples each data bit, the optional parity bit and the stop bit once per bit time, near the middle of the bit. The assembled character is moved from the shift register into a receive buffer, and `rx_ready` is raised.

The CPU reads the buffer by pulsing `rd_strobe`. The parity, framing and overrun flags do not clear on a read. They stay set until the CPU pulses `err_clr`.

Top module: `serial_rx`

## Requirements
- R1: After reset, `rx_ready`, `err_parity`, `err_frame` and `err_overrun` are 0 and `rx_data` is 0.
- R2: A low level on `rxd` is accepted as a start bit only if the line is still low half a bit time later (8 strobes at 16x, 32 at 64x). A shorter low pulse produces no character and leaves `rx_ready` at 0.
- R3: Data arrives least significant bit first. `cfg_len` sets the bit count: 00=5, 01=6, 10=7, 11=8 bits. Bits of `rx_data` above the character length read as 0.
- R4: When `cfg_x64` is 0, one bit time is 16 `rx_tick` strobes. When `cfg_x64` is 1, one bit time is 64 strobes. Every sample after the start bit is taken one full bit time after the previous sample.
- R5: When `cfg_par_en` is 1, one parity bit follows the data. With `cfg_par_even`=1 the data and parity bits together must hold an even number of ones; with 0, an odd number. On a mismatch, `err_parity` is set when the character is transferred.
- R6: If the stop-bit sample is low, `err_frame` is set, and the character is still transferred to the buffer.
- R7: Each transfer sets `rx_ready` and loads `rx_data`. A one-cycle `rd_strobe` clears `rx_ready`. If a transfer happens in the same cycle as `rd_strobe`, the transfer wins.
- R8: If a character is transferred while `rx_ready` is still 1 and has not been read in that cycle, `err_overrun` is set and the buffer takes the new character.
- R9: The error flags remain set through reads of the buffer. They clear only in a cycle where `err_clr` is 1. If an error is set in the same cycle as `err_clr`, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_tick | input | 1 | Receive oversampling strobe, one clock wide |
| rxd | input | 1 | Serial input line, idles high |
| cfg_len | input | 2 | Character length code (5 to 8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_x64 | input | 1 | 1 = 64 strobes per bit, 0 = 16 strobes per bit |
| rd_strobe | input | 1 | CPU read of the receive buffer |
| err_clr | input | 1 | Command pulse that clears all error flags |
| rx_data | output | 8 | Receive buffer |
| rx_ready | output | 1 | Buffer holds a character that has not been read |
| err_parity | output | 1 | Sticky parity error flag |
| err_frame | output | 1 | Sticky framing error flag |
| err_overrun | output | 1 | Sticky overrun flag |

## Verification
The properties assume two things about the inputs. First, `rd_strobe` and `err_clr` are single-cycle pulses given as separate commands. Second, the configuration inputs stay fixed while a character is being received, because the sampling limits are read from them every strobe.

The stimulus keeps to both. It changes the configuration and drives the command pulses only while the line is idle between frames. It drives `rxd` on the falling clock edge, and holds each bit for a whole bit time at the selected factor. This keeps every mid-bit sample well inside its bit, even though start detection can land up to one strobe late.

// File: rtl/serial_rx.sv
`timescale 1ns/1ps
module serial_rx #(
  parameter int DW    = 8,
  parameter int OS_LO = 16,
  parameter int OS_HI = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_tick,
  input  logic          rxd,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_par_en,
  input  logic          cfg_par_even,
  input  logic          cfg_x64,
  input  logic          rd_strobe,
  input  logic          err_clr,
  output logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          err_parity,
  output logic          err_frame,
  output logic          err_overrun
);
  localparam int CW = $clog2(OS_HI);
  localparam int BW = $clog2(DW);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [DW-1:0] shreg;
  logic          pacc;
  logic          pbad;

  logic [CW-1:0] lim_full, lim_half;
  logic [BW-1:0] last_bit;
  logic          at_lim, xfer;

  assign lim_full = cfg_x64 ? CW'(OS_HI - 1)     : CW'(OS_LO - 1);
  assign lim_half = cfg_x64 ? CW'(OS_HI / 2 - 1) : CW'(OS_LO / 2 - 1);
  assign last_bit = BW'(DW - 4) + BW'(cfg_len);
  assign at_lim   = rx_tick && cnt == lim_full;
  assign xfer     = at_lim && st == S_STOP;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= '0;
      pacc  <= 1'b0;
      pbad  <= 1'b0;
    end else if (rx_tick) begin
      case (st)
        S_IDLE: if (!rxd) begin
          st  <= S_START;
          cnt <= '0;
        end
        S_START: if (cnt == lim_half) begin
          cnt <= '0;
          if (rxd) st <= S_IDLE;
          else begin
            st    <= S_DATA;
            bitn  <= '0;
            shreg <= '0;
            pacc  <= 1'b0;
            pbad  <= 1'b0;
          end
        end else cnt <= cnt + 1'b1;
        S_DATA: if (cnt == lim_full) begin
          cnt         <= '0;
          shreg[bitn] <= rxd;
          pacc        <= pacc ^ rxd;
          bitn        <= bitn + 1'b1;
          if (bitn == last_bit) st <= cfg_par_en ? S_PAR : S_STOP;
        end else cnt <= cnt + 1'b1;
        S_PAR: if (cnt == lim_full) begin
          cnt  <= '0;
          pbad <= pacc ^ rxd ^ ~cfg_par_even;
          st   <= S_STOP;
        end else cnt <= cnt + 1'b1;
        S_STOP: if (cnt == lim_full) begin
          cnt <= '0;
          st  <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data     <= '0;
      rx_ready    <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      if (xfer) rx_data <= shreg;

      if (xfer)           rx_ready <= 1'b1;
      else if (rd_strobe) rx_ready <= 1'b0;

      if (xfer && rx_ready && !rd_strobe) err_overrun <= 1'b1;
      else if (err_clr)                   err_overrun <= 1'b0;

      if (xfer && pbad)  err_parity <= 1'b1;
      else if (err_clr)  err_parity <= 1'b0;

      if (xfer && !rxd)  err_frame <= 1'b1;
      else if (err_clr)  err_frame <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_chk.sv
`timescale 1ns/1ps
module serial_rx_chk #(parameter int DW = 8) (
  input logic          clk,
  input logic          rst,
  input logic          rd_strobe,
  input logic          err_clr,
  input logic [DW-1:0] rx_data,
  input logic          rx_ready,
  input logic          err_parity,
  input logic          err_frame,
  input logic          err_overrun,
  input logic          xfer
);
  a_r7_xfer_sets_ready: assert property (@(posedge clk) disable iff (rst)
    xfer |=> rx_ready);
  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    rd_strobe && !xfer |=> !rx_ready);
  a_r7_buffer_holds: assert property (@(posedge clk) disable iff (rst)
    !xfer |=> $stable(rx_data));
  a_r8_overrun_set: assert property (@(posedge clk) disable iff (rst)
    xfer && rx_ready && !rd_strobe |=> err_overrun);
  a_r9_parity_sticky: assert property (@(posedge clk) disable iff (rst)
    err_parity && !err_clr |=> err_parity);
  a_r9_frame_sticky: assert property (@(posedge clk) disable iff (rst)
    err_frame && !err_clr |=> err_frame);
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    err_overrun && !err_clr |=> err_overrun);
  a_r9_clear_all: assert property (@(posedge clk) disable iff (rst)
    err_clr && !xfer |=> !err_parity && !err_frame && !err_overrun);
  a_r9_flags_need_xfer: assert property (@(posedge clk) disable iff (rst)
    !xfer |=> !$rose(err_parity) && !$rose(err_frame) && !$rose(err_overrun));
endmodule

bind serial_rx serial_rx_chk #(.DW(DW)) u_chk (.*);

// File: tb/serial_rx_tb.sv
`timescale 1ns/1ps
module serial_rx_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_tick = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_x64 = 1'b0;
  logic       rd_strobe = 1'b0, err_clr = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, err_parity, err_frame, err_overrun;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  serial_rx u_dut (.*);

  always #2.5 clk = ~clk;

  int tdiv = 0;
  always @(negedge clk) begin
    tdiv    <= (tdiv + 1) % 2;
    rx_tick <= (tdiv == 1);
  end

  // {len[22:21], par_en[20], par_even[19], x64[18], bad_par[17], bad_stop[16], data[15:8], expect[7:0]}
  localparam logic [22:0] VEC [7] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5},
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'h1F},
    {2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h55, 8'h55},
    {2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h2A, 8'h2A},
    {2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h81, 8'h81},
    {2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h3C, 8'h3C},
    {2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(int clocks);
    repeat (clocks) @(negedge clk);
  endtask

  task automatic send(logic [7:0] d, logic [1:0] len, logic pen, logic pev,
                      logic bpar, logic bstop);
    int bt = (cfg_x64 ? 64 : 16) * 2;
    logic [7:0] m = 8'hFF >> (2'd3 - len);
    logic pbit = (^(d & m)) ^ ~pev ^ bpar;
    @(negedge clk);
    rxd = 1'b0; hold(bt);
    for (int i = 0; i < 5 + int'(len); i++) begin
      rxd = d[i]; hold(bt);
    end
    if (pen) begin rxd = pbit; hold(bt); end
    if (bstop) begin
      rxd = 1'b0; hold(bt * 5 / 8);
      rxd = 1'b1; hold(bt - bt * 5 / 8);
    end else begin
      rxd = 1'b1; hold(bt);
    end
    hold(2 * bt);
  endtask

  task automatic pulse_rd();
    rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_clr();
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0; @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    hold(4);
    rst = 1'b0;
    hold(2);
    chk("R1 ready", rx_ready, 0);
    chk("R1 data", rx_data, 0);
    chk("R1 parity", err_parity, 0);
    chk("R1 frame", err_frame, 0);
    chk("R1 overrun", err_overrun, 0);

    foreach (VEC[k]) begin
      logic [22:0] v = VEC[k];
      cfg_len = v[22:21]; cfg_par_en = v[20]; cfg_par_even = v[19]; cfg_x64 = v[18];
      send(v[15:8], v[22:21], v[20], v[19], v[17], v[16]);
      chk("R7 ready after frame", rx_ready, 1);
      chk("R3 R4 data", rx_data, v[7:0]);
      chk("R5 parity flag", err_parity, v[17]);
      chk("R6 frame flag", err_frame, v[16]);
      pulse_rd();
      chk("R7 read clears ready", rx_ready, 0);
      chk("R9 errors survive read", {err_parity, err_frame}, {v[17], v[16]});
      pulse_clr();
      chk("R9 clear", {err_parity, err_frame, err_overrun}, 0);
    end

    cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_x64 = 1'b0;
    rxd = 1'b0; hold(6); rxd = 1'b1; hold(80);
    chk("R2 short low rejected", rx_ready, 0);
    send(8'h69, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R2 next frame clean", rx_data, 8'h69);
    pulse_rd();

    send(8'h12, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    send(8'h34, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 overrun set", err_overrun, 1);
    chk("R8 newest kept", rx_data, 8'h34);
    pulse_rd();
    chk("R9 overrun survives read", err_overrun, 1);
    pulse_clr();
    chk("R9 overrun cleared", err_overrun, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule